// File: doc/BRIEF.md
# Parallel Per-Level Hierarchical Lookup

This block resolves a hierarchical address lookup in a single search cycle. It does not run one content-addressable array several times with a different mask on each pass. Instead it keeps one small binary CAM bank for each fixed level of the address hierarchy. Each bank compares only the key bits that its own level cares about. Every word in a bank uses the same fixed mask, and that mask is a parameter of the level. All banks compare the same incoming key at the same time. A priority stage then picks the deepest level that reports a hit, which is the most specific route.

The result is captured in a register one clock after the key is presented. It carries a hit flag, the winning level, the entry index within that level and the stored associated data. When no level matches, the data comes from a programmable fallback register and the hit flag is low.

Each bank has its own write port, so banks can be loaded or cleared independently, including several in the same clock. The default configuration has three levels of eight entries, with 16-bit keys and 16-bit data. The level masks are 0xF000, 0xFF00 and 0xFFFF for levels 0, 1 and 2.

Top module: `hlk_lookup`

## Requirements
- R1: After reset every entry is invalid, the fallback value is 0x0000 and all result outputs (`res_valid`, `res_hit`, `res_level`, `res_index`, `res_data`) are zero.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high, and low otherwise.
- R3: A valid entry in level L matches a key when the key and the stored key agree on every bit set in that level's mask. The masks are 0xF000 for level 0, 0xFF00 for level 1 and 0xFFFF for level 2.
- R4: When entries in several levels match, the result reports the highest-numbered (deepest) level.
- R5: When several entries in the winning level match, the lowest index wins.
- R6: When no entry matches, `res_hit` is 0, `res_level` and `res_index` are 0, and `res_data` holds the fallback value.
- R7: A pulse on `dflt_we` loads `dflt_data` as the fallback value. It applies to lookups presented in later cycles.
- R8: A write with its valid bit low clears the addressed entry, and the cleared entry never matches afterwards.
- R9: A lookup presented in the same cycle as a write sees the table contents from before that write.
- R10: The per-level write ports are independent; writes to several levels in one cycle all take effect.
- R11: While `lk_valid` is low, `res_hit`, `res_level`, `res_index` and `res_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | LEVELS | Per-level write strobe |
| wr_valid | input | LEVELS | Per-level valid bit written with the entry (0 clears it) |
| wr_index | input | LEVELS*IDX_W | Per-level entry index, level 0 in the low slice |
| wr_key | input | LEVELS*KEY_W | Per-level key to store |
| wr_data | input | LEVELS*DATA_W | Per-level associated data to store |
| dflt_we | input | 1 | Load strobe for the fallback value |
| dflt_data | input | DATA_W | Fallback value |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | KEY_W | Lookup key |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Some level matched |
| res_level | output | LVL_W | Winning level |
| res_index | output | IDX_W | Winning entry index in that level |
| res_data | output | DATA_W | Associated data or fallback value |

## Verification
The hardest situation to reach is a single key that matches in every level at once, and also matches more than one entry in the winning level. A stream of ordinary keys almost never produces both. The bench therefore loads entries whose keys are nested inside one another across the three levels. It then sweeps every value of the upper key byte against low bytes that line up with the deepest level's entries, so each key drives one, two or three levels to hit together. Duplicate keys are then written into a single level, and a write is made in the same cycle as a lookup of the key it changes, so that the within-level order and the old-contents rule both show at the result port.

// File: rtl/hlk_pkg.sv
package hlk_pkg;

   typedef enum logic {
      PRIO_LOW_FIRST  = 1'b0,
      PRIO_HIGH_FIRST = 1'b1
   } prio_dir_e;

   localparam int unsigned DEF_LEVELS  = 3;
   localparam int unsigned DEF_ENTRIES = 8;
   localparam int unsigned DEF_KEY_W   = 16;
   localparam int unsigned DEF_DATA_W  = 16;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hlk_prio_enc.sv
module hlk_prio_enc
   import hlk_pkg::*;
#(
   parameter int unsigned N   = 8,
   parameter prio_dir_e   DIR = PRIO_LOW_FIRST,
   localparam int unsigned IW = idx_width(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   if (N < 1) begin : g_bad_n
      $error("hlk_prio_enc: N must be at least 1");
   end

   assign any = |req;

   if (DIR == PRIO_LOW_FIRST) begin : g_low
      always_comb begin
         logic found;
         found = 1'b0;
         grant = '0;
         idx   = '0;
         for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !found) begin
               found    = 1'b1;
               grant[i] = 1'b1;
               idx      = IW'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         found = 1'b0;
         grant = '0;
         idx   = '0;
         for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i] && !found) begin
               found    = 1'b1;
               grant[i] = 1'b1;
               idx      = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/hlk_bank.sv
module hlk_bank
   import hlk_pkg::*;
#(
   parameter int unsigned     ENTRIES = DEF_ENTRIES,
   parameter int unsigned     KEY_W   = DEF_KEY_W,
   parameter int unsigned     DATA_W  = DEF_DATA_W,
   parameter logic [KEY_W-1:0] MASK   = '1,
   localparam int unsigned    IDX_W   = idx_width(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wvalid,
   input  logic [IDX_W-1:0]  widx,
   input  logic [KEY_W-1:0]  wkey,
   input  logic [DATA_W-1:0] wdata,
   input  logic [KEY_W-1:0]  srch_key,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [DATA_W-1:0] hit_data
);

   if (ENTRIES < 1) begin : g_bad_entries
      $error("hlk_bank: ENTRIES must be at least 1");
   end
   if (KEY_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("hlk_bank: key and data widths must be positive");
   end
   if (MASK == '0) begin : g_bad_mask
      $error("hlk_bank: a level mask with no bits set matches everything");
   end

   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
   logic [ENTRIES-1:0][DATA_W-1:0] data_q;
   logic [ENTRIES-1:0]             match;
   logic [ENTRIES-1:0]             grant;
   logic [KEY_W-1:0]               srch_masked;

   assign srch_masked = srch_key & MASK;

   for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            key_q[e]   <= '0;
            data_q[e]  <= '0;
         end else if (we && widx == IDX_W'(e)) begin
            valid_q[e] <= wvalid;
            key_q[e]   <= wkey & MASK;
            data_q[e]  <= wdata;
         end
      end

      assign match[e] = valid_q[e] && (key_q[e] == srch_masked);
   end

   hlk_prio_enc #(
      .N   (ENTRIES),
      .DIR (PRIO_LOW_FIRST)
   ) i_entry_enc (
      .req   (match),
      .grant (grant),
      .idx   (hit_idx),
      .any   (hit)
   );

   assign hit_data = data_q[hit_idx];

   // R5: at most one entry is granted, and only one that matched
   a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~match) == '0));

   // R5: the granted entry is the lowest-numbered one among the matches
   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((match & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

   // R8: an entry cleared through the write port is not reported next cycle
   a_r8_cleared_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wvalid) |=> !(hit && hit_idx == $past(widx)));

endmodule

// File: rtl/hlk_lookup.sv
module hlk_lookup
   import hlk_pkg::*;
#(
   parameter int unsigned LEVELS  = DEF_LEVELS,
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter int unsigned KEY_W   = DEF_KEY_W,
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter logic [LEVELS*KEY_W-1:0] LEVEL_MASKS = {16'hFFFF, 16'hFF00, 16'hF000},
   localparam int unsigned IDX_W  = idx_width(ENTRIES),
   localparam int unsigned LVL_W  = idx_width(LEVELS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LEVELS-1:0]        wr_en,
   input  logic [LEVELS-1:0]        wr_valid,
   input  logic [LEVELS*IDX_W-1:0]  wr_index,
   input  logic [LEVELS*KEY_W-1:0]  wr_key,
   input  logic [LEVELS*DATA_W-1:0] wr_data,
   input  logic                     dflt_we,
   input  logic [DATA_W-1:0]        dflt_data,
   input  logic                     lk_valid,
   input  logic [KEY_W-1:0]         lk_key,
   output logic                     res_valid,
   output logic                     res_hit,
   output logic [LVL_W-1:0]         res_level,
   output logic [IDX_W-1:0]         res_index,
   output logic [DATA_W-1:0]        res_data
);

   if (LEVELS < 1) begin : g_bad_levels
      $error("hlk_lookup: LEVELS must be at least 1");
   end

   // Deeper levels must refine shallower ones: every bit a level checks
   // is also checked by each level below it in the hierarchy.
   for (genvar l = 1; l < int'(LEVELS); l++) begin : g_mask_chk
      if ((LEVEL_MASKS[l*KEY_W +: KEY_W] & LEVEL_MASKS[(l-1)*KEY_W +: KEY_W])
          != LEVEL_MASKS[(l-1)*KEY_W +: KEY_W]) begin : g_bad_nest
         $error("hlk_lookup: level masks are not nested");
      end
   end

   logic [LEVELS-1:0]             lvl_hit;
   logic [LEVELS-1:0][IDX_W-1:0]  lvl_idx;
   logic [LEVELS-1:0][DATA_W-1:0] lvl_data;
   logic [LEVELS-1:0]             lvl_grant;
   logic [LVL_W-1:0]              win_lvl;
   logic                          any_hit;
   logic [DATA_W-1:0]             dflt_q;

   for (genvar l = 0; l < int'(LEVELS); l++) begin : g_level
      hlk_bank #(
         .ENTRIES (ENTRIES),
         .KEY_W   (KEY_W),
         .DATA_W  (DATA_W),
         .MASK    (LEVEL_MASKS[l*KEY_W +: KEY_W])
      ) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (wr_en[l]),
         .wvalid   (wr_valid[l]),
         .widx     (wr_index[l*IDX_W +: IDX_W]),
         .wkey     (wr_key[l*KEY_W +: KEY_W]),
         .wdata    (wr_data[l*DATA_W +: DATA_W]),
         .srch_key (lk_key),
         .hit      (lvl_hit[l]),
         .hit_idx  (lvl_idx[l]),
         .hit_data (lvl_data[l])
      );
   end

   hlk_prio_enc #(
      .N   (LEVELS),
      .DIR (PRIO_HIGH_FIRST)
   ) i_level_enc (
      .req   (lvl_hit),
      .grant (lvl_grant),
      .idx   (win_lvl),
      .any   (any_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dflt_q <= '0;
      end else if (dflt_we) begin
         dflt_q <= dflt_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_level <= '0;
         res_index <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_hit <= any_hit;
            if (any_hit) begin
               res_level <= win_lvl;
               res_index <= lvl_idx[win_lvl];
               res_data  <= lvl_data[win_lvl];
            end else begin
               res_level <= '0;
               res_index <= '0;
               res_data  <= dflt_q;
            end
         end
      end
   end

   // R2: the result is valid exactly one cycle after the request
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);

   // R4: a hit in the deepest level always wins
   a_r4_deepest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lvl_hit[LEVELS-1]) |=> (res_hit && res_level == LVL_W'(LEVELS-1)));

   // R4: the level picker grants one level, and only one that hit
   a_r4_one_level: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lvl_grant) && ((lvl_grant & ~lvl_hit) == '0));

   // R6: a miss returns the fallback value with the flag low
   a_r6_miss_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lvl_hit == '0) |=> (!res_hit && res_data == $past(dflt_q)));

   // R11: result fields are frozen while no lookup is requested
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> ($stable(res_hit) && $stable(res_level)
                     && $stable(res_index) && $stable(res_data)));

endmodule

// File: tb/test_hlk_lookup.sv
module test_hlk_lookup;

   localparam int L  = 3;
   localparam int E  = 8;
   localparam int KW = 16;
   localparam int DW = 16;
   localparam int IW = 3;
   localparam int LW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [L-1:0]    wr_en = '0;
   logic [L-1:0]    wr_valid = '0;
   logic [L*IW-1:0] wr_index = '0;
   logic [L*KW-1:0] wr_key = '0;
   logic [L*DW-1:0] wr_data = '0;
   logic            dflt_we = 1'b0;
   logic [DW-1:0]   dflt_data = '0;
   logic            lk_valid = 1'b0;
   logic [KW-1:0]   lk_key = '0;
   logic            res_valid;
   logic            res_hit;
   logic [LW-1:0]   res_level;
   logic [IW-1:0]   res_index;
   logic [DW-1:0]   res_data;

   always #2 clk = ~clk;

   hlk_lookup i_hlk_lookup (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_valid(wr_valid),
      .wr_index(wr_index), .wr_key(wr_key), .wr_data(wr_data),
      .dflt_we(dflt_we), .dflt_data(dflt_data), .lk_valid(lk_valid),
      .lk_key(lk_key), .res_valid(res_valid), .res_hit(res_hit),
      .res_level(res_level), .res_index(res_index), .res_data(res_data)
   );

   int checks = 0;
   int errors = 0;

   // Model of the table, kept from the writes the bench makes.
   logic          m_v [L][E];
   logic [KW-1:0] m_k [L][E];
   logic [DW-1:0] m_d [L][E];
   logic [DW-1:0] m_dflt;

   logic          e_hit;
   logic [LW-1:0] e_lvl;
   logic [IW-1:0] e_idx;
   logic [DW-1:0] e_data;

   function automatic logic [KW-1:0] lvl_mask(input int l);
      case (l)
         0:       return 16'hF000;
         1:       return 16'hFF00;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic predict(input logic [KW-1:0] key);
      e_hit = 1'b0; e_lvl = '0; e_idx = '0; e_data = m_dflt;
      for (int l = L - 1; l >= 0 && !e_hit; l--) begin
         for (int i = 0; i < E && !e_hit; i++) begin
            if (m_v[l][i] && (((key ^ m_k[l][i]) & lvl_mask(l)) == '0)) begin
               e_hit = 1'b1; e_lvl = LW'(l); e_idx = IW'(i); e_data = m_d[l][i];
            end
         end
      end
   endtask

   task automatic chk(input logic ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare(input string req);
      chk(res_valid && res_hit == e_hit && res_level == e_lvl &&
          res_index == e_idx && res_data == e_data, req,
          {res_valid, res_hit, 1'b0, res_level, 1'b0, res_index, 8'h00, res_data},
          {1'b1, e_hit, 1'b0, e_lvl, 1'b0, e_idx, 8'h00, e_data});
   endtask

   // Single lookup: drive at a falling edge, sample at the next falling edge.
   task automatic lookup(input logic [KW-1:0] key, input string req);
      predict(key);
      lk_valid = 1'b1; lk_key = key;
      @(negedge clk);
      lk_valid = 1'b0;
      compare(req);
   endtask

   task automatic stage_write(input int l, input int idx, input logic v,
                              input logic [KW-1:0] key, input logic [DW-1:0] d);
      wr_en[l] = 1'b1; wr_valid[l] = v;
      wr_index[l*IW +: IW] = IW'(idx);
      wr_key[l*KW +: KW] = key;
      wr_data[l*DW +: DW] = d;
      m_v[l][idx] = v; m_k[l][idx] = key; m_d[l][idx] = d;
   endtask

   task automatic write1(input int l, input int idx, input logic v,
                         input logic [KW-1:0] key, input logic [DW-1:0] d);
      stage_write(l, idx, v, key, d);
      @(negedge clk);
      wr_en = '0;
   endtask

   logic done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] held;
      for (int l = 0; l < L; l++)
         for (int i = 0; i < E; i++) begin
            m_v[l][i] = 1'b0; m_k[l][i] = '0; m_d[l][i] = '0;
         end
      m_dflt = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(!res_valid && !res_hit && res_level == 0 && res_index == 0 && res_data == 0,
          "R1 reset outputs", {res_valid, res_hit, res_level, res_index, res_data}, 0);
      lookup(16'h1234, "R1 empty table misses with zero fallback");
      lookup(16'hFFFF, "R6 empty table miss");

      // R7: load the fallback value, then miss
      dflt_we = 1'b1; dflt_data = 16'hD00D;
      @(negedge clk);
      dflt_we = 1'b0; m_dflt = 16'hD00D;
      lookup(16'h9000, "R7 fallback after load");

      // Fill: nested keys across the levels
      for (int i = 0; i < E; i++) begin
         write1(0, i, 1'b1, {4'(i), 12'hABC}, 16'h0100 | 16'(i));
         write1(1, i, 1'b1, {4'h1, 4'(i), 8'h5A}, 16'h1100 | 16'(i));
         write1(2, i, 1'b1, {8'h12, 8'(i * 3)}, 16'h2200 | 16'(i));
      end

      // R3 and R4: sweep the upper byte against chosen low bytes
      for (int hi = 0; hi < 256; hi++) begin
         for (int s = 0; s < 6; s++) begin
            logic [7:0] lo;
            case (s)
               0: lo = 8'h00; 1: lo = 8'h03; 2: lo = 8'h06;
               3: lo = 8'h15; 4: lo = 8'h5A; default: lo = 8'hFF;
            endcase
            lookup({8'(hi), lo}, "R3 R4 sweep masked match and level priority");
         end
      end

      // R4: a key hitting all three levels reports level 2
      lookup(16'h1206, "R4 three-level hit picks deepest");

      // R5: duplicate key in one level, lowest index wins
      write1(1, 6, 1'b1, 16'h1300, 16'hBEE6);
      write1(1, 5, 1'b1, 16'h13FF, 16'hBEE5);
      lookup(16'h1377, "R5 duplicates in level 1 pick lowest index");

      // R8: clear level 2 entry 2, key falls back to level 1
      write1(2, 2, 1'b0, 16'h1206, 16'h0000);
      lookup(16'h1206, "R8 cleared entry no longer matches");

      // R9: write and lookup in the same cycle see the old contents
      predict(16'h1299);
      lk_valid = 1'b1; lk_key = 16'h1299;
      stage_write(2, 7, 1'b1, 16'h1299, 16'h7777);
      @(negedge clk);
      lk_valid = 1'b0; wr_en = '0;
      compare("R9 same-cycle lookup uses old contents");
      lookup(16'h1299, "R9 write visible on next lookup");

      // R10: all three ports in one cycle
      stage_write(0, 0, 1'b1, 16'hA000, 16'hA0A0);
      stage_write(1, 0, 1'b1, 16'hB100, 16'hB1B1);
      stage_write(2, 0, 1'b1, 16'hC222, 16'hC2C2);
      @(negedge clk);
      wr_en = '0;
      lookup(16'hA123, "R10 level 0 write in shared cycle");
      lookup(16'hB1EE, "R10 level 1 write in shared cycle");
      lookup(16'hC222, "R10 level 2 write in shared cycle");

      // R11: outputs hold while idle
      lookup(16'hC222, "R11 setup lookup");
      held = res_data;
      repeat (3) begin
         @(negedge clk);
         chk(!res_valid && res_hit && res_level == 2 && res_index == 0 && res_data == held,
             "R11 R2 idle hold", {res_valid, res_hit, res_level, res_index, res_data},
             {1'b0, 1'b1, 2'd2, 3'd0, held});
      end

      // R6: miss after hits restores fallback and zero level and index
      lookup(16'hF00F, "R6 miss after hits");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule